// File: doc/BRIEF.md
# Debug ROM Table Walker

This block finds the debug components of a system without software help. It gets a debug base address and a start pulse. It then reads the discovery table through a simple 32-bit read port, one read at a time. The port carries an address and a valid flag out, and a ready flag, read data and an error flag back. First it reads the identification words of the table page and the memory-type word. Then it steps through the entry words. For every component marked present, it fetches the peripheral and component identification words.

Each non-zero entry yields one record on a valid/ready output stream. The record holds the component's base address, its start address (the base moved down by the component's extra 4 KB pages), its class code and a present flag. The walk ends on a zero entry, on a read error, or when the entry limit is reached. The block then holds `done` until the next start. Nested tables are reported as class 1 records and are not entered.

Top module: `rom_table_walker`

## Requirements
- R1: After reset, `done`, `err`, `rd_valid`, `rec_valid`, `tbl_found`, `tbl_fmt` and `tbl_sysmem` are all 0.
- R2: A start with base 0xFFFFFFFF issues no read and reaches `done` with `tbl_found`=0, `err`=0 and no record.
- R3: Otherwise the table page is base[31:12]. `tbl_found`=1 and `tbl_fmt` equals base bit 1 (1 = current format, 0 = legacy). The first five reads are page offsets 0xFF0, 0xFF4, 0xFF8, 0xFFC, then 0xFCC. `tbl_sysmem` takes bit 0 of the word read at 0xFCC.
- R4: Entries are read at page offsets 0, 4, 8, … in order. An entry equal to 0 ends the walk with `done`=1 and `err`=0, and produces no record.
- R5: A non-zero entry with bit 0 clear causes no further reads. It emits one record with `rec_present`=0, `rec_class`=0 and `rec_start`=`rec_base`.
- R6: An entry with bit 0 set causes nine reads at the component base, in this order: offsets 0xFE0, 0xFE4, 0xFE8, 0xFEC, 0xFD0, 0xFF0, 0xFF4, 0xFF8, 0xFFC. One record with `rec_present`=1 follows.
- R7: The component base equals the page base plus entry bits [31:12], read as a signed count of 4 KB pages and taken modulo 2^32.
- R8: `rec_start` equals the base minus 4 KB times bits [7:4] of the word at 0xFD0. `rec_class` is bits [7:4] of the word at 0xFF4 (1 = nested table, 9 = debug component).
- R9: A read that completes with `rd_err`=1 ends the walk at once with `done`=1 and `err`=1. No further read or record follows.
- R10: After MAX_ENTRIES non-zero entries the walk ends with `done`=1 and `err`=0 without reading another entry.
- R11: `rd_valid` and `rd_addr` hold until `rd_ready`. A record holds its valid flag and fields until `rec_ready`.
- R12: A start while `done` is high begins a fresh walk and clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk; taken when idle or done |
| base_addr | input | 32 | Debug base value |
| rd_valid | output | 1 | Read request pending |
| rd_addr | output | 32 | Read address |
| rd_ready | input | 1 | Read completes this cycle |
| rd_data | input | 32 | Read data, valid with `rd_ready` |
| rd_err | input | 1 | Read failed, valid with `rd_ready` |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Record consumed |
| rec_base | output | 32 | Component base address |
| rec_start | output | 32 | Component start address |
| rec_class | output | 4 | Component class code |
| rec_present | output | 1 | Entry marked present |
| tbl_found | output | 1 | A table was given |
| tbl_fmt | output | 1 | Table uses current format |
| tbl_sysmem | output | 1 | System memory reported present |
| done | output | 1 | Walk finished (held) |
| err | output | 1 | Walk aborted by a read error |

## Verification
The bench uses an entry with a negative page offset. A design that treats the offset as unsigned would report a base 4 GB off instead of one page below the table. It uses a component with a non-zero size field and a non-present entry between present ones. A walker that reads IDs for absent components shows extra reads, and one that forgets the size shows start equal to base. It injects an error in the middle of a component's ID reads, which must stop the walk with no record. It also fills a whole page with absent entries to check that the walk ends at exactly the entry limit. Read and record ready flags are stalled throughout, so a design that drops or changes a request before the handshake produces a wrong address log.

// File: rtl/rom_table_walker.sv
module rom_table_walker #(
  parameter int MAX_ENTRIES = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] base_addr,
  output logic        rd_valid,
  output logic [31:0] rd_addr,
  input  logic        rd_ready,
  input  logic [31:0] rd_data,
  input  logic        rd_err,
  output logic        rec_valid,
  input  logic        rec_ready,
  output logic [31:0] rec_base,
  output logic [31:0] rec_start,
  output logic [3:0]  rec_class,
  output logic        rec_present,
  output logic        tbl_found,
  output logic        tbl_fmt,
  output logic        tbl_sysmem,
  output logic        done,
  output logic        err
);
  localparam int CW = $clog2(MAX_ENTRIES + 1);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_ENT, S_COMP, S_EMIT, S_FIN} st_t;
  st_t st;

  logic [19:0]   page, cbase;
  logic [CW-1:0] eidx;
  logic [3:0]    seq, csize, ccls;
  logic          cpres;
  logic [11:0]   hdr_off, comp_off;
  logic          at_limit, hs;

  assign at_limit = (eidx == CW'(MAX_ENTRIES));
  assign hs       = rd_valid && rd_ready;
  assign hdr_off  = (seq == 4'd4) ? 12'hFCC : 12'hFF0 + {6'd0, seq, 2'b00};
  assign comp_off = (seq < 4'd4)  ? 12'hFE0 + {6'd0, seq, 2'b00} :
                    (seq == 4'd4) ? 12'hFD0 : 12'hFF0 + {6'd0, seq - 4'd5, 2'b00};

  always_comb begin
    case (st)
      S_HDR:   rd_addr = {page, hdr_off};
      S_ENT:   rd_addr = {page, 12'h000} + 32'({eidx, 2'b00});
      S_COMP:  rd_addr = {cbase, comp_off};
      default: rd_addr = 32'h0;
    endcase
  end

  assign rd_valid    = (st == S_HDR) || (st == S_COMP) || (st == S_ENT && !at_limit);
  assign rec_valid   = (st == S_EMIT);
  assign rec_base    = {cbase, 12'h000};
  assign rec_start   = {cbase - {16'd0, csize}, 12'h000};
  assign rec_class   = ccls;
  assign rec_present = cpres;
  assign done        = (st == S_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      page <= '0; cbase <= '0; eidx <= '0; seq <= '0;
      csize <= '0; ccls <= '0; cpres <= 1'b0;
      tbl_found <= 1'b0; tbl_fmt <= 1'b0; tbl_sysmem <= 1'b0; err <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_FIN: if (start) begin
          err        <= 1'b0;
          seq        <= '0;
          eidx       <= '0;
          tbl_sysmem <= 1'b0;
          page       <= base_addr[31:12];
          tbl_found  <= (base_addr != 32'hFFFF_FFFF);
          tbl_fmt    <= (base_addr != 32'hFFFF_FFFF) && base_addr[1];
          st         <= (base_addr != 32'hFFFF_FFFF) ? S_HDR : S_FIN;
        end
        S_HDR: if (hs) begin
          if (rd_err) begin
            err <= 1'b1; st <= S_FIN;
          end else if (seq == 4'd4) begin
            tbl_sysmem <= rd_data[0]; st <= S_ENT;
          end else seq <= seq + 4'd1;
        end
        S_ENT: if (at_limit) st <= S_FIN;
        else if (hs) begin
          if (rd_err) begin
            err <= 1'b1; st <= S_FIN;
          end else if (rd_data == 32'h0) st <= S_FIN;
          else begin
            eidx  <= eidx + CW'(1);
            cbase <= page + rd_data[31:12];
            cpres <= rd_data[0];
            csize <= '0;
            ccls  <= '0;
            seq   <= '0;
            st    <= rd_data[0] ? S_COMP : S_EMIT;
          end
        end
        S_COMP: if (hs) begin
          if (rd_err) begin
            err <= 1'b1; st <= S_FIN;
          end else begin
            if (seq == 4'd4) csize <= rd_data[7:4];
            if (seq == 4'd6) ccls  <= rd_data[7:4];
            if (seq == 4'd8) st <= S_EMIT;
            else seq <= seq + 4'd1;
          end
        end
        S_EMIT: if (rec_ready) st <= S_ENT;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  // R11
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_base) && $stable(rec_start) && $stable(rec_class));
  // R9
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && !rd_valid && !rec_valid);
  // R5
  absent_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_present |-> rec_start == rec_base && rec_class == 4'd0);
  // R10
  entry_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eidx <= CW'(MAX_ENTRIES));
  // R2
  no_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_found |-> !rd_valid && !rec_valid);
endmodule

// File: tb/tb_rom_table_walker.sv
`timescale 1ns/1ps
module tb_rom_table_walker;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [31:0] base_addr = 0;
  logic        rd_valid, rd_ready = 1, rd_err = 0;
  logic [31:0] rd_addr, rd_data = 0;
  logic        rec_valid, rec_ready = 1, rec_present;
  logic [31:0] rec_base, rec_start;
  logic [3:0]  rec_class;
  logic        tbl_found, tbl_fmt, tbl_sysmem, done, err;

  rom_table_walker dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] mem [logic [31:0]];
  logic        fill_on = 0, err_on = 0, stall = 0;
  logic [19:0] fill_page = 0;
  logic [31:0] err_addr = 0;
  int cyc = 0, nrd = 0, nrec = 0, npres = 0;
  logic [31:0] rd_log [64];
  logic [31:0] rb_log [16], rs_log [16], last_base;
  logic [3:0]  rc_log [16];
  logic        rp_log [16];

  function automatic logic [31:0] mdl(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    if (fill_on && a[31:12] == fill_page) return 32'h0000_2002;
    return 32'h0;
  endfunction

  always @(negedge clk) begin
    cyc++;
    rd_ready  = !stall || (cyc % 3 != 0);
    rec_ready = !stall || (cyc % 4 == 1) || (cyc % 4 == 2);
    rd_data   = mdl(rd_addr);
    rd_err    = err_on && (rd_addr == err_addr);
    if (rd_valid && rd_ready) begin
      if (nrd < 64) rd_log[nrd] = rd_addr;
      nrd++;
    end
    if (rec_valid && rec_ready) begin
      if (nrec < 16) begin
        rb_log[nrec] = rec_base; rs_log[nrec] = rec_start;
        rc_log[nrec] = rec_class; rp_log[nrec] = rec_present;
      end
      if (rec_present) npres++;
      last_base = rec_base;
      nrec++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic run_walk(input logic [31:0] b);
    int n = 0;
    @(negedge clk);
    nrd = 0; nrec = 0; npres = 0;
    start = 1; base_addr = b;
    @(negedge clk);
    start = 0;
    while (!done && n < 50000) begin @(negedge clk); n++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got done=0 expected done=1");
    end
  endtask

  task automatic t_reset();
    chk("R1 done", done, 0); chk("R1 err", err, 0);
    chk("R1 rd_valid", rd_valid, 0); chk("R1 rec_valid", rec_valid, 0);
    chk("R1 flags", {tbl_found, tbl_fmt, tbl_sysmem}, 0);
  endtask

  task automatic t_no_table();
    mem.delete();
    run_walk(32'hFFFF_FFFF);
    chk("R2 reads", nrd, 0); chk("R2 found", tbl_found, 0);
    chk("R2 err", err, 0); chk("R2 records", nrec, 0);
  endtask

  task automatic t_main();
    logic [31:0] ex [27];
    mem.delete(); stall = 1;
    mem[32'h4000_0FCC] = 32'h1;
    mem[32'h4000_0000] = 32'h0001_0003;
    mem[32'h4000_0004] = 32'h0000_2002;
    mem[32'h4000_0008] = 32'hFFFF_F003;
    mem[32'h4001_0FD0] = 32'h30; mem[32'h4001_0FF4] = 32'h90;
    mem[32'h3FFF_FFD0] = 32'h04; mem[32'h3FFF_FFF4] = 32'h10;
    run_walk(32'h4000_0003);
    ex = '{32'h40000FF0, 32'h40000FF4, 32'h40000FF8, 32'h40000FFC, 32'h40000FCC,
           32'h40000000,
           32'h40010FE0, 32'h40010FE4, 32'h40010FE8, 32'h40010FEC, 32'h40010FD0,
           32'h40010FF0, 32'h40010FF4, 32'h40010FF8, 32'h40010FFC,
           32'h40000004, 32'h40000008,
           32'h3FFFFFE0, 32'h3FFFFFE4, 32'h3FFFFFE8, 32'h3FFFFFEC, 32'h3FFFFFD0,
           32'h3FFFFFF0, 32'h3FFFFFF4, 32'h3FFFFFF8, 32'h3FFFFFFC,
           32'h4000000C};
    chk("R4 read count", nrd, 27);
    for (int i = 0; i < 27; i++)
      chk($sformatf("R3/R4/R6 read %0d addr", i), rd_log[i], ex[i]);
    chk("R3 found", tbl_found, 1); chk("R3 fmt", tbl_fmt, 1); chk("R3 sysmem", tbl_sysmem, 1);
    chk("R4 err", err, 0); chk("R4 records", nrec, 3);
    chk("R8 rec0 base", rb_log[0], 32'h4001_0000);
    chk("R8 rec0 start", rs_log[0], 32'h4000_D000);
    chk("R8 rec0 class", rc_log[0], 9); chk("R6 rec0 present", rp_log[0], 1);
    chk("R5 rec1 base", rb_log[1], 32'h4000_2000);
    chk("R5 rec1 start", rs_log[1], 32'h4000_2000);
    chk("R5 rec1 class", rc_log[1], 0); chk("R5 rec1 present", rp_log[1], 0);
    chk("R7 rec2 base", rb_log[2], 32'h3FFF_F000);
    chk("R7 rec2 start", rs_log[2], 32'h3FFF_F000);
    chk("R8 rec2 class", rc_log[2], 1); chk("R6 rec2 present", rp_log[2], 1);
    stall = 0;
  endtask

  task automatic t_legacy_empty();
    mem.delete();
    run_walk(32'h5000_0000);
    chk("R12 restart done", done, 1);
    chk("R3 legacy fmt", tbl_fmt, 0); chk("R3 sysmem clear", tbl_sysmem, 0);
    chk("R4 empty reads", nrd, 6); chk("R4 empty records", nrec, 0);
    chk("R4 last read", rd_log[5], 32'h5000_0000);
  endtask

  task automatic t_error();
    mem.delete(); stall = 1;
    mem[32'h6000_0000] = 32'h0000_1001;
    err_on = 1; err_addr = 32'h6000_1FD0;
    run_walk(32'h6000_0002);
    chk("R9 err", err, 1); chk("R9 done", done, 1);
    chk("R9 reads", nrd, 11); chk("R9 records", nrec, 0);
    chk("R9 last read", rd_log[10], 32'h6000_1FD0);
    err_on = 0; stall = 0;
  endtask

  task automatic t_limit();
    mem.delete(); stall = 1;
    fill_on = 1; fill_page = 20'h70000;
    run_walk(32'h7000_0000);
    chk("R10 records", nrec, 1024); chk("R10 reads", nrd, 5 + 1024);
    chk("R10 err", err, 0); chk("R10 present", npres, 0);
    chk("R10 last base", last_base, 32'h7000_2000);
    chk("R12 err cleared after error walk", err, 0);
    fill_on = 0; stall = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_no_table();
    t_main();
    t_legacy_empty();
    t_error();
    t_limit();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule